// File: doc/BRIEF.md
# SDRAM Command Decoder with Bank Tracking and Byte Masks

This block sits on the device side of a 32-bit, four-bank SDRAM command bus. In each clock cycle it reads the chip select, the row strobe, the column strobe, the write enable, the clock enable, the bank select, the 11-bit address and the four byte-mask lines. It reports the command as a one-hot vector, together with the decoded bank, row, column, auto-precharge qualifier and precharge-all qualifier. Command decode and its qualifiers are combinational within the cycle.

It keeps a registered open/closed flag and the open row for each bank, and it holds the last mode op-code that was loaded. It flags protocol errors: an access to a closed bank, or an activate to a bank that is already open. It also produces two per-byte enable masks. The write mask follows the mask pins in the same cycle. The read mask follows them two cycles later.

Top module: `sdram_cmd_decoder`

## Requirements
- R1: While cs_ni is high, cmd_o reports only NOP (bit 0), whatever the other pins are. Bank state and mode op-code stay unchanged.
- R2: With cs_ni low and cke_i high, {ras_ni,cas_ni,we_ni} decodes onto the cmd_o bits as follows:
  - 111 gives bit 0, NOP.
  - 011 gives bit 1, ACTIVE.
  - 101 gives bit 2, READ.
  - 100 gives bit 3, WRITE.
  - 110 gives bit 4, BURST STOP.
  - 010 gives bit 5, PRECHARGE.
  - 001 gives bit 6, AUTO REFRESH.
  - 000 gives bit 8, LOAD MODE.
- R3: With cke_i low, code 001 gives bit 7, SELF REFRESH. Every other code gives NOP and leaves the bank state unchanged.
- R4: ACTIVE marks bank ba_i open and records addr_i[10:0] as its row. Both are visible from the next cycle on bank_open_o[b] and open_row_o[b*11 +: 11].
- R5: In the same cycle as a READ or WRITE, col_o shows addr_i[7:0], bank_o shows ba_i and auto_pre_o shows addr_i[10].
- R6: On PRECHARGE, the bank state changes from the next cycle:
  - With addr_i[10] low, only bank ba_i closes.
  - With addr_i[10] high, pre_all_o is high in that cycle, all banks close and ba_i is ignored.
- R7: After a READ or WRITE with auto-precharge, the accessed bank still shows open in the following cycle. It shows closed one cycle after that.
- R8: err_o is high in the same cycle for either of these, and cmd_o still reports the command:
  - a READ or WRITE to a closed bank;
  - an ACTIVE to an open bank.
  A bank whose auto-precharge is pending counts as closed.
- R9: LOAD MODE captures addr_i[10:0] into mode_op_o, visible from the next cycle. The value is held until the next LOAD MODE.
- R10: wr_be_o[i] equals ~dqm_i[i] in the same cycle. Lane i covers data bits 8i+7:8i.
- R11: rd_oe_o[i] equals the inverse of dqm_i[i] as it was sampled two cycles earlier.
- R12: After reset, all banks are closed, every open row is 0, mode_op_o is 0 and rd_oe_o is all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_ni | input | 1 | Chip select, active low |
| ras_ni | input | 1 | Row strobe, active low |
| cas_ni | input | 1 | Column strobe, active low |
| we_ni | input | 1 | Write enable, active low |
| cke_i | input | 1 | Clock enable |
| ba_i | input | 2 | Bank select |
| addr_i | input | 11 | Address / op-code bus |
| dqm_i | input | 4 | Byte mask, one bit per lane |
| cmd_o | output | 9 | One-hot decoded command |
| bank_o | output | 2 | Decoded bank |
| row_o | output | 11 | Decoded row |
| col_o | output | 8 | Decoded column |
| auto_pre_o | output | 1 | Access carries auto-precharge |
| pre_all_o | output | 1 | Precharge targets all banks |
| mode_op_o | output | 11 | Last loaded mode op-code |
| err_o | output | 1 | Protocol error strobe |
| bank_open_o | output | 4 | Open flag per bank |
| open_row_o | output | 44 | Open row per bank, 11 bits each |
| wr_be_o | output | 4 | Write byte enables |
| rd_oe_o | output | 4 | Read byte output enables |

## Verification
The checker verifies on every cycle that:
- chip-select-high and clock-enable-low cycles decode only to the allowed commands;
- an activate records its bank and row;
- precharge-all empties the bank state;
- a pending auto-precharge closes its bank on the second edge;
- the error strobe rises for both illegal patterns;
- the read mask trails the pins by two cycles.

Only the bench's scenarios can show that the decode table matches bit for bit and that the column is truncated to eight bits. The same holds for a single-bank precharge leaving the other banks open, the op-code being held across later commands and the same-cycle write mask.

// File: rtl/sdram_dec_pkg.sv
package sdram_dec_pkg;
  localparam int unsigned CMD_W = 9;

  typedef enum int unsigned {
    C_NOP  = 0,
    C_ACT  = 1,
    C_RD   = 2,
    C_WR   = 3,
    C_BST  = 4,
    C_PRE  = 5,
    C_AREF = 6,
    C_SREF = 7,
    C_LMR  = 8
  } cmd_idx_e;

  typedef logic [CMD_W-1:0] cmd_vec_t;
endpackage

// File: rtl/sdram_cmd_decode.sv
module sdram_cmd_decode
  import sdram_dec_pkg::*;
(
  input  logic     cs_ni,
  input  logic     ras_ni,
  input  logic     cas_ni,
  input  logic     we_ni,
  input  logic     cke_i,
  input  logic     ap_i,
  output cmd_vec_t cmd_o,
  output logic     auto_pre_o,
  output logic     pre_all_o
);
  cmd_idx_e sel;

  always_comb begin
    sel = C_NOP;
    if (!cs_ni) begin
      case ({ras_ni, cas_ni, we_ni})
        3'b011:  sel = C_ACT;
        3'b101:  sel = C_RD;
        3'b100:  sel = C_WR;
        3'b110:  sel = C_BST;
        3'b010:  sel = C_PRE;
        3'b001:  sel = cke_i ? C_AREF : C_SREF;
        3'b000:  sel = C_LMR;
        default: sel = C_NOP;
      endcase
      // only refresh is legal with clock enable low
      if (!cke_i && sel != C_SREF) sel = C_NOP;
    end
  end

  assign cmd_o      = cmd_vec_t'(1) << sel;
  assign auto_pre_o = (cmd_o[C_RD] | cmd_o[C_WR]) & ap_i;
  assign pre_all_o  = cmd_o[C_PRE] & ap_i;
endmodule

// File: rtl/sdram_bank_tracker.sv
module sdram_bank_tracker #(
  parameter int unsigned NUM_BANKS = 4,
  parameter int unsigned ROW_W     = 11,
  localparam int unsigned BA_W     = $clog2(NUM_BANKS)
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       act_i,
  input  logic                       acc_i,
  input  logic                       pre_i,
  input  logic                       pre_all_i,
  input  logic                       auto_pre_i,
  input  logic [BA_W-1:0]            ba_i,
  input  logic [ROW_W-1:0]           row_i,
  output logic [NUM_BANKS-1:0]       open_o,
  output logic [NUM_BANKS*ROW_W-1:0] open_row_o,
  output logic                       err_o
);
  logic [NUM_BANKS-1:0] open_q, eff, open_d;
  logic                 pend_q;
  logic [BA_W-1:0]      pend_ba_q;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic             hit;
    logic [ROW_W-1:0] row_q;

    assign hit = (ba_i == BA_W'(b));
    // pending auto-precharge already counts as closed
    assign eff[b] = open_q[b] & ~(pend_q && (pend_ba_q == BA_W'(b)));
    assign open_d[b] = (act_i && hit)                 ? 1'b1 :
                       (pre_i && (pre_all_i || hit))  ? 1'b0 : eff[b];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)           row_q <= '0;
      else if (act_i && hit) row_q <= row_i;
    end

    assign open_row_o[b*ROW_W +: ROW_W] = row_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      open_q    <= '0;
      pend_q    <= 1'b0;
      pend_ba_q <= '0;
    end else begin
      open_q    <= open_d;
      pend_q    <= acc_i & auto_pre_i;
      pend_ba_q <= ba_i;
    end
  end

  assign open_o = open_q;
  assign err_o  = (acc_i & ~eff[ba_i]) | (act_i & eff[ba_i]);
endmodule

// File: rtl/sdram_dqm_pipe.sv
module sdram_dqm_pipe #(
  parameter int unsigned LANES  = 4,
  parameter int unsigned RD_LAT = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [LANES-1:0] dqm_i,
  output logic [LANES-1:0] wr_be_o,
  output logic [LANES-1:0] rd_oe_o
);
  logic [LANES-1:0] stg_q [RD_LAT];

  for (genvar s = 0; s < RD_LAT; s++) begin : g_stg
    if (s == 0) begin : g_head
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg_q[s] <= '0;
        else         stg_q[s] <= dqm_i;
      end
    end else begin : g_tail
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg_q[s] <= '0;
        else         stg_q[s] <= stg_q[s-1];
      end
    end
  end

  // writes mask immediately, reads after the pipeline delay
  assign wr_be_o = ~dqm_i;
  assign rd_oe_o = ~stg_q[RD_LAT-1];
endmodule

// File: rtl/sdram_cmd_decoder.sv
module sdram_cmd_decoder
  import sdram_dec_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 4,
  parameter int unsigned ADDR_W    = 11,
  parameter int unsigned COL_W     = 8,
  parameter int unsigned LANES     = 4,
  parameter int unsigned RD_LAT    = 2,
  parameter int unsigned AP_BIT    = 10,
  localparam int unsigned BA_W     = $clog2(NUM_BANKS)
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        cs_ni,
  input  logic                        ras_ni,
  input  logic                        cas_ni,
  input  logic                        we_ni,
  input  logic                        cke_i,
  input  logic [BA_W-1:0]             ba_i,
  input  logic [ADDR_W-1:0]           addr_i,
  input  logic [LANES-1:0]            dqm_i,
  output logic [CMD_W-1:0]            cmd_o,
  output logic [BA_W-1:0]             bank_o,
  output logic [ADDR_W-1:0]           row_o,
  output logic [COL_W-1:0]            col_o,
  output logic                        auto_pre_o,
  output logic                        pre_all_o,
  output logic [ADDR_W-1:0]           mode_op_o,
  output logic                        err_o,
  output logic [NUM_BANKS-1:0]        bank_open_o,
  output logic [NUM_BANKS*ADDR_W-1:0] open_row_o,
  output logic [LANES-1:0]            wr_be_o,
  output logic [LANES-1:0]            rd_oe_o
);
  cmd_vec_t          cmd;
  logic              ap, pall;
  logic [ADDR_W-1:0] mode_q;

  sdram_cmd_decode u_decode (
    .cs_ni      (cs_ni),
    .ras_ni     (ras_ni),
    .cas_ni     (cas_ni),
    .we_ni      (we_ni),
    .cke_i      (cke_i),
    .ap_i       (addr_i[AP_BIT]),
    .cmd_o      (cmd),
    .auto_pre_o (ap),
    .pre_all_o  (pall)
  );

  sdram_bank_tracker #(
    .NUM_BANKS (NUM_BANKS),
    .ROW_W     (ADDR_W)
  ) u_tracker (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .act_i      (cmd[C_ACT]),
    .acc_i      (cmd[C_RD] | cmd[C_WR]),
    .pre_i      (cmd[C_PRE]),
    .pre_all_i  (pall),
    .auto_pre_i (ap),
    .ba_i       (ba_i),
    .row_i      (addr_i),
    .open_o     (bank_open_o),
    .open_row_o (open_row_o),
    .err_o      (err_o)
  );

  sdram_dqm_pipe #(
    .LANES  (LANES),
    .RD_LAT (RD_LAT)
  ) u_dqm (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .dqm_i   (dqm_i),
    .wr_be_o (wr_be_o),
    .rd_oe_o (rd_oe_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         mode_q <= '0;
    else if (cmd[C_LMR]) mode_q <= addr_i;
  end

  assign cmd_o      = cmd;
  assign bank_o     = ba_i;
  assign row_o      = addr_i;
  assign col_o      = addr_i[COL_W-1:0];
  assign auto_pre_o = ap;
  assign pre_all_o  = pall;
  assign mode_op_o  = mode_q;
endmodule

// File: rtl/sdram_cmd_decoder_chk.sv
module sdram_cmd_decoder_chk
  import sdram_dec_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 4,
  parameter int unsigned ADDR_W    = 11,
  parameter int unsigned LANES     = 4,
  parameter int unsigned RD_LAT    = 2,
  localparam int unsigned BA_W     = $clog2(NUM_BANKS)
) (
  input logic                        clk_i,
  input logic                        rst_ni,
  input logic                        cs_ni,
  input logic                        cke_i,
  input logic [ADDR_W-1:0]           addr_i,
  input logic [LANES-1:0]            dqm_i,
  input logic [CMD_W-1:0]            cmd_o,
  input logic [BA_W-1:0]             bank_o,
  input logic                        auto_pre_o,
  input logic                        pre_all_o,
  input logic                        err_o,
  input logic [NUM_BANKS-1:0]        bank_open_o,
  input logic [NUM_BANKS*ADDR_W-1:0] open_row_o,
  input logic [LANES-1:0]            rd_oe_o
);
  logic [1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (cnt_q != 2'd3) cnt_q <= cnt_q + 2'd1;
  end

  // R1
  cs_hi_nop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_ni |-> cmd_o == (cmd_vec_t'(1) << C_NOP));

  // R3
  cke_lo_cmd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cke_i |-> (cmd_o[C_NOP] || cmd_o[C_SREF]));

  // R4
  act_opens_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_o[C_ACT] |=> bank_open_o[$past(bank_o)] &&
      (open_row_o[$past(bank_o)*ADDR_W +: ADDR_W] == $past(addr_i)));

  // R6
  pre_all_close_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_o[C_PRE] && pre_all_o) |=> bank_open_o == '0);

  // R7
  auto_pre_close_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((cnt_q == 2'd3) && $past(auto_pre_o, 2) &&
     !($past(cmd_o[C_ACT]) && ($past(bank_o) == $past(bank_o, 2))))
    |-> !bank_open_o[$past(bank_o, 2)]);

  // R8
  acc_closed_err_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((cmd_o[C_RD] || cmd_o[C_WR]) && !bank_open_o[bank_o]) |-> err_o);

  // R8
  act_open_err_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((cnt_q == 2'd3) && cmd_o[C_ACT] && bank_open_o[bank_o] &&
     !($past(auto_pre_o) && ($past(bank_o) == bank_o))) |-> err_o);

  if (RD_LAT == 2) begin : g_rd_lat
    // R11
    rd_mask_lat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cnt_q == 2'd3) |-> rd_oe_o == ~$past(dqm_i, 2));
  end
endmodule

bind sdram_cmd_decoder sdram_cmd_decoder_chk #(
  .NUM_BANKS (NUM_BANKS),
  .ADDR_W    (ADDR_W),
  .LANES     (LANES),
  .RD_LAT    (RD_LAT)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cs_ni       (cs_ni),
  .cke_i       (cke_i),
  .addr_i      (addr_i),
  .dqm_i       (dqm_i),
  .cmd_o       (cmd_o),
  .bank_o      (bank_o),
  .auto_pre_o  (auto_pre_o),
  .pre_all_o   (pre_all_o),
  .err_o       (err_o),
  .bank_open_o (bank_open_o),
  .open_row_o  (open_row_o),
  .rd_oe_o     (rd_oe_o)
);

// File: tb/sdram_cmd_decoder_bench.sv
module sdram_cmd_decoder_bench;
  localparam int CLK_PERIOD = 10;

  localparam int K_CMD  = 0;
  localparam int K_ERR  = 1;
  localparam int K_AP   = 2;
  localparam int K_PALL = 3;
  localparam int K_COL  = 4;
  localparam int K_BANK = 5;
  localparam int K_OPEN = 6;
  localparam int K_ROW  = 7;
  localparam int K_MODE = 8;
  localparam int K_WBE  = 9;
  localparam int K_ROE  = 10;

  localparam logic [31:0] E_NOP  = 32'h001;
  localparam logic [31:0] E_ACT  = 32'h002;
  localparam logic [31:0] E_RD   = 32'h004;
  localparam logic [31:0] E_WR   = 32'h008;
  localparam logic [31:0] E_BST  = 32'h010;
  localparam logic [31:0] E_PRE  = 32'h020;
  localparam logic [31:0] E_AREF = 32'h040;
  localparam logic [31:0] E_SREF = 32'h080;
  localparam logic [31:0] E_LMR  = 32'h100;

  typedef struct {
    int          cyc;
    int          kind;
    int          idx;
    logic [31:0] exp;
    string       tag;
  } item_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, cke = 1'b1;
  logic [1:0]  ba = '0;
  logic [10:0] addr = '0;
  logic [3:0]  dqm = '0;
  logic [8:0]  cmd;
  logic [1:0]  bank;
  logic [10:0] row, mode_op;
  logic [7:0]  col;
  logic        ap, pall, err;
  logic [3:0]  bopen, wbe, roe;
  logic [43:0] orow;

  item_t sb[$];
  int    cyc = 0;
  int    checks = 0;
  int    fails = 0;
  bit    done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc = cyc + 1;

  sdram_cmd_decoder u_sdram_cmd_decoder (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .ras_ni(ras_n), .cas_ni(cas_n),
    .we_ni(we_n), .cke_i(cke), .ba_i(ba), .addr_i(addr), .dqm_i(dqm),
    .cmd_o(cmd), .bank_o(bank), .row_o(row), .col_o(col), .auto_pre_o(ap),
    .pre_all_o(pall), .mode_op_o(mode_op), .err_o(err), .bank_open_o(bopen),
    .open_row_o(orow), .wr_be_o(wbe), .rd_oe_o(roe)
  );

  function automatic logic [31:0] getval(input int kind, input int idx);
    case (kind)
      K_CMD:   return 32'(cmd);
      K_ERR:   return 32'(err);
      K_AP:    return 32'(ap);
      K_PALL:  return 32'(pall);
      K_COL:   return 32'(col);
      K_BANK:  return 32'(bank);
      K_OPEN:  return 32'(bopen);
      K_ROW:   return 32'(orow[idx*11 +: 11]);
      K_MODE:  return 32'(mode_op);
      K_WBE:   return 32'(wbe);
      K_ROE:   return 32'(roe);
      default: return 32'hdead;
    endcase
  endfunction

  // monitor: compare every item due this cycle
  always @(negedge clk) begin
    for (int i = sb.size() - 1; i >= 0; i--) begin
      if (sb[i].cyc <= cyc) begin
        logic [31:0] got;
        got = getval(sb[i].kind, sb[i].idx);
        checks++;
        if (got !== sb[i].exp || sb[i].cyc != cyc) begin
          fails++;
          $display("FAIL %s kind=%0d idx=%0d cyc=%0d: got %0h expected %0h",
                   sb[i].tag, sb[i].kind, sb[i].idx, cyc, got, sb[i].exp);
        end
        sb.delete(i);
      end
    end
  end

  task automatic put(input logic c, input logic r, input logic a, input logic w,
                     input logic k, input logic [1:0] b, input logic [10:0] ad,
                     input logic [3:0] m);
    @(posedge clk);
    #1;
    cs_n = c; ras_n = r; cas_n = a; we_n = w; cke = k; ba = b; addr = ad; dqm = m;
  endtask

  task automatic nop(input logic [3:0] m);
    put(1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 2'd0, 11'h000, m);
  endtask

  task automatic expect_at(input int dly, input int kind, input int idx,
                           input logic [31:0] v, input string tag);
    item_t it;
    it.cyc = cyc + dly; it.kind = kind; it.idx = idx; it.exp = v; it.tag = tag;
    sb.push_back(it);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    nop(4'h0);
    expect_at(0, K_OPEN, 0, 32'h0, "R12");
    expect_at(0, K_ROE, 0, 32'hF, "R12");
    expect_at(0, K_MODE, 0, 32'h0, "R12");
    expect_at(0, K_ROW, 2, 32'h0, "R12");
    expect_at(0, K_CMD, 0, E_NOP, "R2");

    // chip select high over a load-mode pattern
    put(1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 2'd0, 11'h155, 4'h0);
    expect_at(0, K_CMD, 0, E_NOP, "R1");
    expect_at(1, K_MODE, 0, 32'h0, "R1");
    expect_at(1, K_OPEN, 0, 32'h0, "R1");

    put(1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 2'd1, 11'h2A5, 4'h0);
    expect_at(0, K_CMD, 0, E_ACT, "R2");
    expect_at(0, K_ERR, 0, 32'h0, "R8");
    expect_at(1, K_OPEN, 0, 32'h2, "R4");
    expect_at(1, K_ROW, 1, 32'h2A5, "R4");

    put(1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 2'd1, 11'h011, 4'h0);
    expect_at(0, K_CMD, 0, E_ACT, "R8");
    expect_at(0, K_ERR, 0, 32'h1, "R8");

    put(1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 2'd2, 11'h000, 4'h0);
    expect_at(0, K_CMD, 0, E_RD, "R2");
    expect_at(0, K_ERR, 0, 32'h1, "R8");

    put(1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 2'd1, 11'h33C, 4'h0);
    expect_at(0, K_CMD, 0, E_RD, "R2");
    expect_at(0, K_COL, 0, 32'h3C, "R5");
    expect_at(0, K_BANK, 0, 32'h1, "R5");
    expect_at(0, K_AP, 0, 32'h0, "R5");
    expect_at(0, K_ERR, 0, 32'h0, "R8");

    put(1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 2'd1, 11'h481, 4'h0);
    expect_at(0, K_CMD, 0, E_WR, "R2");
    expect_at(0, K_AP, 0, 32'h1, "R5");
    expect_at(0, K_COL, 0, 32'h81, "R5");
    expect_at(1, K_OPEN, 0, 32'h2, "R7");
    expect_at(2, K_OPEN, 0, 32'h0, "R7");
    nop(4'h0);
    nop(4'h0);

    put(1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 2'd0, 11'h100, 4'h0);
    put(1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 2'd2, 11'h7FF, 4'h0);
    put(1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 2'd3, 11'h055, 4'h0);
    expect_at(1, K_OPEN, 0, 32'hD, "R4");
    expect_at(1, K_ROW, 2, 32'h7FF, "R4");
    expect_at(1, K_ROW, 3, 32'h055, "R4");

    put(1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 2'd2, 11'h000, 4'h0);
    expect_at(0, K_CMD, 0, E_PRE, "R2");
    expect_at(0, K_PALL, 0, 32'h0, "R6");
    expect_at(1, K_OPEN, 0, 32'h9, "R6");

    put(1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 2'd2, 11'h400, 4'h0);
    expect_at(0, K_PALL, 0, 32'h1, "R6");
    expect_at(1, K_OPEN, 0, 32'h0, "R6");

    put(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 2'd0, 11'h123, 4'h0);
    expect_at(0, K_CMD, 0, E_NOP, "R3");
    expect_at(1, K_OPEN, 0, 32'h0, "R3");

    put(1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 2'd0, 11'h000, 4'h0);
    expect_at(0, K_CMD, 0, E_AREF, "R2");
    put(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 2'd0, 11'h000, 4'h0);
    expect_at(0, K_CMD, 0, E_SREF, "R3");
    put(1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 2'd0, 11'h000, 4'h0);
    expect_at(0, K_CMD, 0, E_BST, "R2");

    put(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 2'd0, 11'h233, 4'h0);
    expect_at(0, K_CMD, 0, E_LMR, "R2");
    expect_at(1, K_MODE, 0, 32'h233, "R9");
    nop(4'h0);
    expect_at(1, K_MODE, 0, 32'h233, "R9");

    nop(4'h5);
    expect_at(0, K_WBE, 0, 32'hA, "R10");
    expect_at(2, K_ROE, 0, 32'hA, "R11");
    nop(4'hE);
    expect_at(0, K_WBE, 0, 32'h1, "R10");
    expect_at(2, K_ROE, 0, 32'h1, "R11");
    nop(4'h0);
    expect_at(2, K_ROE, 0, 32'hF, "R11");

    // pending auto-precharge counts as closed
    put(1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 2'd0, 11'h0AA, 4'h0);
    put(1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 2'd0, 11'h410, 4'h0);
    expect_at(0, K_ERR, 0, 32'h0, "R8");
    put(1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 2'd0, 11'h010, 4'h0);
    expect_at(0, K_ERR, 0, 32'h1, "R8");
    put(1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 2'd0, 11'h0AB, 4'h0);
    expect_at(0, K_ERR, 0, 32'h0, "R8");
    nop(4'h0);

    repeat (4) @(posedge clk);
    @(negedge clk);
    #1;
    if (sb.size() != 0) begin
      fails++;
      $display("FAIL scoreboard: got %0d pending items expected 0", sb.size());
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule